// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block predicts control flow at instruction fetch. The fetch PC is looked up in a direct-mapped table in the same cycle that the instruction cache is read. On a hit the block reports that the fetched word is a branch. It also gives the stored target, a taken/not-taken guess taken from a 2-bit saturating counter, and the branch kind (conditional or unconditional). From these it forms the next fetch PC. A miss predicts fall-through, PC+4.

A later pipeline stage resolves each branch and returns the actual outcome, target and kind through a resolve port. It also echoes the prediction that this block made for that instruction at fetch. The block compares outcome against prediction. On any mismatch it raises a one-cycle flush in the following cycle, with the corrected PC. In the same edge it writes the table. A taken branch that is not present gets a new entry. A branch that is present has its counter stepped, and its target and kind are refreshed when it resolves taken. A branch that resolves not-taken and is not present leaves the table untouched.

Top module: `btb_pred`

## Requirements
- R1: After reset every entry is invalid, so every fetch PC misses, and `flush_o` is 0.
- R2: The index is PC[5:2] and the tag is PC[31:6]. A fetch hits when the entry at its index is valid and holds its tag. On a hit, `pred_target_o` and `pred_kind_o` (0 conditional, 1 unconditional) are the stored values, and `pred_taken_o` is bit 1 of the counter. `next_pc_o` is the target when the prediction is taken and PC+4 otherwise.
- R3: On a miss, `hit_o` and `pred_taken_o` are 0 and `next_pc_o` is the fetch PC+4.
- R4: A resolved taken branch with no matching entry is written into its index with its tag, target and kind. Its counter is set to 2 (weakly taken), so a later fetch of that PC hits and predicts taken.
- R5: A resolved not-taken branch with no matching entry does not change the table, and a later fetch of that PC still misses.
- R6: A resolve that matches an entry moves its counter one step toward 3 if taken and toward 0 if not taken. The counter saturates at both ends. A not-taken outcome never removes the entry.
- R7: Starting from a strongly-taken counter (3), one not-taken outcome still leaves the prediction taken, and a second one flips it to not taken.
- R8: A resolve is a misprediction when the echoed direction differs from the outcome, or when both are taken and the echoed target differs from the actual target. A misprediction raises `flush_o` for exactly the next cycle. A correct prediction raises no flush.
- R9: While `flush_o` is high, `fix_pc_o` is the actual target if the branch was taken, and its PC+4 if not.
- R10: Two PCs with the same index and different tags never share a prediction. Allocating one replaces the other, which then misses.
- R11: A taken resolve that matches an entry overwrites the stored target and kind with the actual ones.
- R12: A fetch and a resolve in the same cycle see the table as it stood before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | PC being fetched |
| hit_o | output | 1 | Fetch PC found in the table (is a branch) |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | 32 | Predicted target on a hit |
| pred_kind_o | output | 1 | Branch kind on a hit, 0 conditional, 1 unconditional |
| next_pc_o | output | 32 | Predicted next fetch PC |
| res_valid_i | input | 1 | A branch is resolved this cycle |
| res_pc_i | input | 32 | PC of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_target_i | input | 32 | Actual target |
| res_kind_i | input | 1 | Actual branch kind |
| res_pred_taken_i | input | 1 | Direction that was predicted at fetch |
| res_pred_target_i | input | 32 | Next PC that was predicted at fetch when taken |
| flush_o | output | 1 | Misprediction, flush the pipe (one cycle) |
| fix_pc_o | output | 32 | Corrected fetch PC while flushing |

## Verification
The properties assume that every input is driven to a known value from reset release onward, and that `res_valid_i` is low while reset is held. The flush properties look back one cycle at the resolve inputs, so they also rely on at most one resolve per cycle. PCs and targets in the stimulus are word aligned. In most cycles the echoed prediction is the bench's own view of what the table predicts for the resolved PC, as a real pipeline would supply it. Some resolves carry a deliberately stale target or a flipped direction, so that each of the three misprediction cases occurs.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic {
    KIND_COND   = 1'b0,
    KIND_UNCOND = 1'b1
  } br_kind_e;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_LSB - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] fa_idx_i,
  output logic             fa_valid_o,
  output logic [TAG_W-1:0] fa_tag_o,
  output logic [PC_W-1:0]  fa_tgt_o,
  output logic             fa_kind_o,
  output logic [1:0]       fa_ctr_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic             rb_valid_o,
  output logic [TAG_W-1:0] rb_tag_o,
  output logic [PC_W-1:0]  rb_tgt_o,
  output logic             rb_kind_o,
  output logic [1:0]       rb_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  logic             wr_kind_i,
  input  logic [1:0]       wr_ctr_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic               kind_q [ENTRIES];
  logic [1:0]         ctr_q  [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      tgt_q[wr_idx_i]  <= wr_tgt_i;
      kind_q[wr_idx_i] <= wr_kind_i;
      ctr_q[wr_idx_i]  <= wr_ctr_i;
    end
  end

  assign fa_valid_o = valid_q[fa_idx_i];
  assign fa_tag_o   = tag_q[fa_idx_i];
  assign fa_tgt_o   = tgt_q[fa_idx_i];
  assign fa_kind_o  = kind_q[fa_idx_i];
  assign fa_ctr_o   = ctr_q[fa_idx_i];

  assign rb_valid_o = valid_q[rb_idx_i];
  assign rb_tag_o   = tag_q[rb_idx_i];
  assign rb_tgt_o   = tgt_q[rb_idx_i];
  assign rb_kind_o  = kind_q[rb_idx_i];
  assign rb_ctr_o   = ctr_q[rb_idx_i];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_LSB - IDX_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  logic             ent_kind_i,
  input  logic [1:0]       ent_ctr_i,
  output logic             hit_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  target_o,
  output logic             kind_o,
  output logic [PC_W-1:0]  next_pc_o
);
  logic [TAG_W-1:0] tag;

  assign idx_o    = pc_i[IDX_LSB +: IDX_W];
  assign tag      = pc_i[PC_W-1 -: TAG_W];
  assign hit_o    = ent_valid_i && (ent_tag_i == tag);
  assign taken_o  = hit_o && ent_ctr_i[1];
  assign target_o = hit_o ? ent_tgt_i : '0;
  assign kind_o   = hit_o && ent_kind_i;
  assign next_pc_o = taken_o ? ent_tgt_i : pc_i + PC_W'(4);
endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_LSB - IDX_W
) (
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic             res_taken_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             res_kind_i,
  input  logic             res_pred_taken_i,
  input  logic [PC_W-1:0]  res_pred_target_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  logic             ent_kind_i,
  input  logic [1:0]       ent_ctr_i,
  output logic             wr_en_o,
  output logic [TAG_W-1:0] wr_tag_o,
  output logic [PC_W-1:0]  wr_tgt_o,
  output logic             wr_kind_o,
  output logic [1:0]       wr_ctr_o,
  output logic             mispredict_o,
  output logic [PC_W-1:0]  fix_pc_o
);
  logic [TAG_W-1:0] tag;
  logic             ent_hit;

  assign idx_o   = res_pc_i[IDX_LSB +: IDX_W];
  assign tag     = res_pc_i[PC_W-1 -: TAG_W];
  assign ent_hit = ent_valid_i && (ent_tag_i == tag);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_tag_o  = tag;
    wr_tgt_o  = res_target_i;
    wr_kind_o = res_kind_i;
    wr_ctr_o  = CTR_WEAK_TAKEN;
    if (res_valid_i) begin
      if (ent_hit) begin
        wr_en_o  = 1'b1;
        wr_ctr_o = ctr_step(ent_ctr_i, res_taken_i);
        if (!res_taken_i) begin
          wr_tgt_o  = ent_tgt_i;
          wr_kind_o = ent_kind_i;
        end
      end else if (res_taken_i) begin
        wr_en_o = 1'b1;  // allocate taken branches only
      end
    end
  end

  assign mispredict_o = res_valid_i &&
                        ((res_taken_i != res_pred_taken_i) ||
                         (res_taken_i && (res_target_i != res_pred_target_i)));
  assign fix_pc_o = res_taken_i ? res_target_i : res_pc_i + PC_W'(4);
endmodule

// File: rtl/btb_pred.sv
module btb_pred #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            hit_o,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o,
  output logic            pred_kind_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_kind_i,
  input  logic            res_pred_taken_i,
  input  logic [PC_W-1:0] res_pred_target_i,
  output logic            flush_o,
  output logic [PC_W-1:0] fix_pc_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_LSB - IDX_W;

  logic [IDX_W-1:0] fa_idx, rb_idx;
  logic             fa_valid, rb_valid, fa_kind, rb_kind;
  logic [TAG_W-1:0] fa_tag, rb_tag, wr_tag;
  logic [PC_W-1:0]  fa_tgt, rb_tgt, wr_tgt, fix_pc_d;
  logic [1:0]       fa_ctr, rb_ctr, wr_ctr;
  logic             wr_en, wr_kind, mispredict;
  logic             flush_q;
  logic [PC_W-1:0]  fix_pc_q;

  btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u_store (
    .clk_i, .rst_ni,
    .fa_idx_i(fa_idx), .fa_valid_o(fa_valid), .fa_tag_o(fa_tag),
    .fa_tgt_o(fa_tgt), .fa_kind_o(fa_kind), .fa_ctr_o(fa_ctr),
    .rb_idx_i(rb_idx), .rb_valid_o(rb_valid), .rb_tag_o(rb_tag),
    .rb_tgt_o(rb_tgt), .rb_kind_o(rb_kind), .rb_ctr_o(rb_ctr),
    .wr_en_i(wr_en), .wr_idx_i(rb_idx), .wr_tag_i(wr_tag),
    .wr_tgt_i(wr_tgt), .wr_kind_i(wr_kind), .wr_ctr_i(wr_ctr)
  );

  btb_lookup #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u_lookup (
    .pc_i(fetch_pc_i), .idx_o(fa_idx),
    .ent_valid_i(fa_valid), .ent_tag_i(fa_tag), .ent_tgt_i(fa_tgt),
    .ent_kind_i(fa_kind), .ent_ctr_i(fa_ctr),
    .hit_o, .taken_o(pred_taken_o), .target_o(pred_target_o),
    .kind_o(pred_kind_o), .next_pc_o
  );

  btb_update #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u_update (
    .res_valid_i, .res_pc_i, .res_taken_i, .res_target_i, .res_kind_i,
    .res_pred_taken_i, .res_pred_target_i,
    .idx_o(rb_idx),
    .ent_valid_i(rb_valid), .ent_tag_i(rb_tag), .ent_tgt_i(rb_tgt),
    .ent_kind_i(rb_kind), .ent_ctr_i(rb_ctr),
    .wr_en_o(wr_en), .wr_tag_o(wr_tag), .wr_tgt_o(wr_tgt),
    .wr_kind_o(wr_kind), .wr_ctr_o(wr_ctr),
    .mispredict_o(mispredict), .fix_pc_o(fix_pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q  <= 1'b0;
      fix_pc_q <= '0;
    end else begin
      flush_q  <= mispredict;
      fix_pc_q <= fix_pc_d;
    end
  end

  assign flush_o  = flush_q;
  assign fix_pc_o = fix_pc_q;
endmodule

// File: rtl/btb_pred_chk.sv
module btb_pred_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            hit_o,
  input logic            pred_taken_o,
  input logic [PC_W-1:0] pred_target_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i,
  input logic [PC_W-1:0] res_target_i,
  input logic            res_pred_taken_i,
  input logic [PC_W-1:0] res_pred_target_i,
  input logic            flush_o,
  input logic [PC_W-1:0] fix_pc_o
);
  // R3
  miss_falls_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + PC_W'(4)));

  // R2
  taken_follows_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && pred_taken_o) |-> next_pc_o == pred_target_o);

  // R8
  flush_needs_resolve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(res_valid_i));

  // R8
  dir_miss_flushes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i != res_pred_taken_i) |=> flush_o);

  // R8
  tgt_miss_flushes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i && res_pred_taken_i && res_target_i != res_pred_target_i)
    |=> flush_o);

  // R9
  fix_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && $past(res_taken_i)) |-> fix_pc_o == $past(res_target_i));

  // R9
  fix_fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !$past(res_taken_i)) |-> fix_pc_o == $past(res_pc_i) + PC_W'(4));
endmodule

bind btb_pred btb_pred_chk #(.PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc_i),
  .hit_o(hit_o), .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o),
  .next_pc_o(next_pc_o), .res_valid_i(res_valid_i), .res_pc_i(res_pc_i),
  .res_taken_i(res_taken_i), .res_target_i(res_target_i),
  .res_pred_taken_i(res_pred_taken_i), .res_pred_target_i(res_pred_target_i),
  .flush_o(flush_o), .fix_pc_o(fix_pc_o)
);

// File: tb/sim_btb_pred.sv
`timescale 1ns/1ps
module sim_btb_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, ptk, pkind;
  logic [31:0] ptgt, npc;
  logic        rv = 1'b0, rtk = 1'b0, rkind = 1'b0, rptk = 1'b0;
  logic [31:0] rpc = '0, rtgt = '0, rptgt = '0;
  logic        flush;
  logic [31:0] fix;

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference table
  bit          m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  bit          m_knd [16];
  int          m_ctr [16];
  bit          e_flush = 0;
  logic [31:0] e_fix = '0;

  always #2 clk = ~clk;

  btb_pred u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .hit_o(hit), .pred_taken_o(ptk), .pred_target_o(ptgt),
    .pred_kind_o(pkind), .next_pc_o(npc),
    .res_valid_i(rv), .res_pc_i(rpc), .res_taken_i(rtk),
    .res_target_i(rtgt), .res_kind_i(rkind),
    .res_pred_taken_i(rptk), .res_pred_target_i(rptgt),
    .flush_o(flush), .fix_pc_o(fix)
  );

  function automatic bit m_hit(input logic [31:0] pc);
    return m_v[pc[5:2]] && m_tag[pc[5:2]] == pc[31:6];
  endfunction

  function automatic bit m_taken(input logic [31:0] pc);
    return m_hit(pc) && m_ctr[pc[5:2]] >= 2;
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] pc);
    return m_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit eh;
    eh = m_hit(fetch_pc);
    chk(hit == eh, "hit", 32'(hit), 32'(eh));
    chk(ptk == m_taken(fetch_pc), "taken", 32'(ptk), 32'(m_taken(fetch_pc)));
    chk(npc == m_next(fetch_pc), "next_pc", npc, m_next(fetch_pc));
    if (eh) begin
      chk(ptgt == m_tgt[fetch_pc[5:2]], "target", ptgt, m_tgt[fetch_pc[5:2]]);
      chk(pkind == m_knd[fetch_pc[5:2]], "kind", 32'(pkind), 32'(m_knd[fetch_pc[5:2]]));
    end
    chk(flush == e_flush, "flush", 32'(flush), 32'(e_flush));
    if (e_flush) chk(fix == e_fix, "fix_pc", fix, e_fix);
  endtask

  task automatic model_edge();
    int i;
    e_flush = 0;
    if (rv) begin
      e_flush = (rtk != rptk) || (rtk && rtgt != rptgt);
      e_fix   = rtk ? rtgt : rpc + 32'd4;
      i = int'(rpc[5:2]);
      if (m_hit(rpc)) begin
        if (rtk) begin
          if (m_ctr[i] < 3) m_ctr[i]++;
          m_tgt[i] = rtgt;
          m_knd[i] = rkind;
        end else if (m_ctr[i] > 0) m_ctr[i]--;
      end else if (rtk) begin
        m_v[i] = 1; m_tag[i] = rpc[31:6]; m_tgt[i] = rtgt;
        m_knd[i] = rkind; m_ctr[i] = 2;
      end
    end
  endtask

  // one clock: drive, compare before edge, then advance model at the edge
  task automatic cyc(input logic [31:0] fpc, input bit v, input logic [31:0] pc,
                     input bit tk, input logic [31:0] tgt, input bit kd,
                     input bit ptk_in, input logic [31:0] ptgt_in);
    @(negedge clk);
    fetch_pc = fpc; rv = v; rpc = pc; rtk = tk; rtgt = tgt; rkind = kd;
    rptk = ptk_in; rptgt = ptgt_in;
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  // resolve with the echo a pipeline would carry (table view of that PC)
  task automatic res(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                     input bit kd, input logic [31:0] fpc);
    cyc(fpc, 1, pc, tk, tgt, kd, m_taken(pc), m_next(pc));
  endtask

  task automatic idle(input logic [31:0] fpc);
    cyc(fpc, 0, '0, 0, '0, 0, 0, '0);
  endtask

  initial begin
    logic [31:0] a, b;
    a = 32'h0000_1010;
    b = a + 32'd64;  // same index, other tag
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_ctr[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_knd[i] = 0;
    end
    #1;
    // R1: outputs during reset
    chk(hit == 0, "reset hit", 32'(hit), 0);
    chk(flush == 0, "reset flush", 32'(flush), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    for (int i = 0; i < 4; i++) idle(32'h100 + 32'(i * 4));

    req = "R5";  // not-taken miss leaves table alone
    res(a, 0, 32'h2000, 0, a);
    idle(a);
    idle(a);

    req = "R4";  // taken miss allocates weakly taken; flush since NT was predicted
    res(a, 1, 32'h2000, 0, a);
    idle(a);
    idle(a + 32'd4);

    req = "R6";
    res(a, 1, 32'h2000, 0, a);  // -> 3
    idle(a);
    res(a, 1, 32'h2000, 0, a);  // saturates at 3
    idle(a);

    req = "R7";
    res(a, 0, 32'h2000, 0, a);  // -> 2, still taken
    idle(a);
    res(a, 0, 32'h2000, 0, a);  // -> 1, not taken
    idle(a);

    req = "R6";
    res(a, 0, 32'h2000, 0, a);  // -> 0
    res(a, 0, 32'h2000, 0, a);  // stays 0, entry kept
    idle(a);
    res(a, 1, 32'h2000, 0, a);  // -> 1
    res(a, 1, 32'h2000, 0, a);  // -> 2
    idle(a);

    req = "R11";  // new target and kind, target mismatch flushes
    res(a, 1, 32'h3000, 1, a);
    idle(a);

    req = "R12";  // fetch sees pre-update table in the resolve cycle
    res(a, 1, 32'h3400, 1, a);
    idle(a);

    req = "R8";
    cyc(a, 1, a, 1, 32'h3400, 1, 1, 32'h3400);  // correct: no flush
    cyc(a, 1, a, 1, 32'h3400, 1, 1, 32'h3404);  // stale target
    cyc(a, 1, a, 0, 32'h3400, 1, 1, 32'h3400);  // predicted taken, went NT
    cyc(a, 1, a, 1, 32'h3400, 1, 0, 32'h3400);  // predicted NT, went taken
    idle(a);
    idle(a);

    req = "R9";
    res(a + 32'd8, 0, 32'h5000, 0, a);
    res(a + 32'd12, 1, 32'h5100, 0, a);
    idle(a);

    req = "R10";
    idle(b);
    res(b, 1, 32'h6000, 0, b);
    idle(b);
    idle(a);

    req = "R2";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] pc, fp, tg;
      int sel;
      pc  = 32'h0000_1000 + 32'($urandom % 24) * 4;
      fp  = 32'h0000_1000 + 32'($urandom % 24) * 4;
      tg  = 32'h0000_4000 + 32'($urandom % 8) * 4;
      sel = $urandom % 8;
      if (sel < 2) idle(fp);
      else if (sel < 7) res(pc, 1'($urandom % 3 != 0), tg, 1'($urandom), fp);
      else cyc(fp, 1, pc, 1'($urandom), tg, 1'($urandom), 1'($urandom), tg + 32'd4);
      if (n == 300) req = "R3";
    end
    idle(32'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule